// File: doc/BRIEF.md
# Tag Anticollision Sequencer

This block is the transmit and listen sequencer of a passive RFID tag that has to share the reader field with other tags. After power-up it stays silent for a pseudo-random number of header periods. It then sends a short fixed header and watches a three-bit listening window for the reader's acknowledge. A tag that gets its acknowledge in the right slot sends its 12-byte identity frame over and over, with a short silent gap after each frame, until the reader starts a command inside one of those gaps. A tag that sees the reader talking to someone else stays silent until the channel goes quiet. A tag that hears nothing backs off for a fresh random delay and tries again.

All timing is counted in half-bit periods. Each half-bit period is a fixed number of carrier-cycle strobes. The output is a modulation level that can change only at half-bit boundaries, so a later analog stage can load the coil from it directly. Decoding of the command itself is handled outside the block: an external decoder reports whether the command was a quiet request, was finished, or was a global release.

Top module: `tag_anticoll_seq`

## Requirements
- R1: During reset `mod_out` and `cmd_stb` are 0. After reset the first header begins after exactly D header periods of 8 half-bits each, where D = `id_bytes[2:0]` + 1.
- R2: A header is 8 half-bits with modulation 0,1,1,1,1,1,1,0 in time order. It is followed by a 6-half-bit listening window with no modulation.
- R3: A reader pulse seen in half-bit 2 or 3 of the listening window (counting from 0) is the tag's acknowledge. The ID frame starts in the next half-bit.
- R4: An ID frame is 98 bits: a start bit of 1, then the 96 bits of `id_bytes` with byte 0 (`id_bytes[7:0]`) first and each byte MSB first, then a stop bit of 0. A bit of value 1 is sent as (modulated, unmodulated) half-bits, and a bit of value 0 as (unmodulated, modulated).
- R5: Each frame is followed by a 6-half-bit unmodulated gap. If no reader pulse arrives in the gap, the frame repeats.
- R6: A reader pulse inside a gap raises `cmd_stb` for exactly one clock, and modulation stops until the command resolves.
- R7: While `wr_busy` is 1 at the start of a data bit, that bit is sent as 0. Start and stop bits are unaffected.
- R8: With no reader pulse in the listening window, the tag waits a new delay of 1 to 8 header periods after the window and then sends the header again. Delays come from an 8-bit LFSR, next = {q[6:0], q[7]^q[5]^q[4]^q[3]}, seeded with {5'b10110, `id_bytes[2:0]`}.
- R9: A reader pulse in listening-window half-bit 0, 1, 4 or 5 puts the tag in a silent hold. The hold lasts until `SILENCE_HB` consecutive half-bits pass with no pulse, and then a new back-off starts.
- R10: `cmd_quiet` sampled while a command is pending makes the tag silent. In that state it ignores reader pulses and gives no `cmd_stb`, until `glob_rel` starts a new back-off of 1 to 8 header periods.
- R11: `cmd_done` sampled while a command is pending resumes ID frames from the next half-bit.
- R12: `mod_out` and the sequencer state change only at half-bit boundaries, and a half-bit lasts `HALF_CYC` carrier strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| car_stb | input | 1 | One-clock strobe per carrier cycle |
| rdr_pulse | input | 1 | Demodulated reader gap/pulse detector output |
| id_bytes | input | 96 | ID page bytes 0..11, byte k at bits [8k+7:8k] |
| wr_busy | input | 1 | Serial-side EEPROM write in progress |
| cmd_quiet | input | 1 | Decoder: pending command is a quiet request |
| cmd_done | input | 1 | Decoder: pending command finished, resume ID frames |
| glob_rel | input | 1 | Decoder: global command releasing a quiet tag |
| mod_out | output | 1 | Coil modulation level, half-bit resolution |
| cmd_stb | output | 1 | One-clock strobe: reader started a command in a gap |

## Verification
The hardest situation to reach from the ports is the indefinite hold. It needs a reader pulse that falls inside the listening window but outside the tag's own slot, followed by further traffic spaced more closely than the silence limit. The bench locks onto the first rising edge of the header and from there places every reader pulse, command flag and sample at an exact half-bit offset. This lets it hit window half-bits 0 and 4, keep the hold alive with repeated pulses, and then bound when the next header appears. The ID frames are compared half-bit by half-bit against a bench model, using random ID contents and both extreme seeds.

// File: rtl/tas_pkg.sv
// Package: shared types and helpers for the tag anticollision sequencer.
// Assumes: the header is always 8 half-bits and back-off draws are 3 bits wide.
package tas_pkg;

    typedef enum logic [2:0] {
        ST_BACKOFF,
        ST_HEADER,
        ST_LISTEN,
        ST_HOLD,
        ST_ID_TX,
        ST_ID_GAP,
        ST_CMD,
        ST_QUIET
    } tas_state_e;

    localparam int HDR_HB    = 8;   // header length in half-bits
    localparam int WIN_HB    = 6;   // listening window / gap length in half-bits
    localparam int BO_BITS   = 3;   // back-off draw width (1..8 periods)
    localparam int LFSR_W    = 8;

    // Largest of three counts, used to size the shared phase counter.
    function automatic int tas_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tas_timebase.sv
// Module: half-bit timebase.
// Counts carrier strobes and pulses hb_tick on the strobe that closes each
// half-bit. Assumes HALF_CYC >= 2.
module tas_timebase #(
    parameter int HALF_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic car_stb,
    output logic hb_tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cyc_q;

    assign hb_tick = car_stb && (cyc_q == CW'(HALF_CYC - 1));

    // Carrier-cycle counter that wraps once per half-bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (car_stb) begin
            cyc_q <= hb_tick ? '0 : cyc_q + 1'b1;
        end
    end
endmodule

// File: rtl/tas_pulse_catch.sv
// Module: reader pulse catcher.
// Remembers any reader pulse seen during the current half-bit so that the
// sequencer, which only acts on hb_tick, sees short pulses too.
module tas_pulse_catch (
    input  logic clk,
    input  logic rst_n,
    input  logic rdr_pulse,
    input  logic hb_tick,
    output logic hb_pulse
);
    logic seen_q;

    assign hb_pulse = seen_q | rdr_pulse;

    // Sticky flag, cleared when the half-bit closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (hb_tick) begin
            seen_q <= 1'b0;
        end else if (rdr_pulse) begin
            seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/tas_lfsr.sv
// Module: back-off delay generator.
// 8-bit LFSR loaded at reset from a fixed pattern plus the ID seed bits.
// The low bits are the current draw; step advances to the next draw.
module tas_lfsr
    import tas_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BO_BITS-1:0] seed,
    input  logic               step,
    output logic [BO_BITS-1:0] draw
);
    localparam logic [LFSR_W-BO_BITS-1:0] SEED_HI = 5'b10110;

    logic [LFSR_W-1:0] q;
    logic [LFSR_W-1:0] seed_full;

    assign seed_full = {SEED_HI, seed};
    assign draw      = q[BO_BITS-1:0];

    // Advance function: shift left, feedback from taps 7,5,4,3.
    function automatic logic [LFSR_W-1:0] adv(input logic [LFSR_W-1:0] v);
        return {v[LFSR_W-2:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    // State register; reset loads the value after the seed, because the
    // seed itself is spent on the power-up delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= adv(seed_full);
        end else if (step) begin
            q <= adv(q);
        end
    end
endmodule

// File: rtl/tas_frame_gen.sv
// Module: ID frame bit source.
// Holds the value of the bit now on air and picks the next one when the
// sequencer enters a new bit. Bit 0 is the start bit (1), bits 1..8*ID_BYTES
// are ID data (byte 0 first, MSB first), and the last bit is the stop bit (0).
// A data bit whose start finds wr_busy high is sent as 0.
module tas_frame_gen #(
    parameter int ID_BYTES = 12,
    parameter int CNT_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hb_tick,
    input  logic                  tx_next,
    input  logic                  start,
    input  logic [CNT_W-1:0]      idx_next,
    input  logic [8*ID_BYTES-1:0] id_bytes,
    input  logic                  wr_busy,
    output logic                  cur_bit
);
    localparam int DATA_BITS = 8 * ID_BYTES;
    localparam int DATA_W    = $clog2(DATA_BITS);

    logic [CNT_W-2:0]  bit_k;
    logic [CNT_W-2:0]  pos;
    logic              in_data;
    logic [DATA_W-1:0] sel;
    logic              data_val;

    assign bit_k    = idx_next[CNT_W-1:1];
    assign pos      = bit_k - 1'b1;
    assign in_data  = (bit_k != '0) && (pos < (CNT_W-1)'(DATA_BITS));
    assign sel      = {pos[DATA_W-1:3], ~pos[2:0]};
    assign data_val = in_data && !wr_busy && id_bytes[sel];

    // Load the next bit value at each bit boundary inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_bit <= 1'b0;
        end else if (hb_tick && tx_next) begin
            if (start) begin
                cur_bit <= 1'b1;
            end else if (!idx_next[0]) begin
                cur_bit <= data_val;
            end
        end
    end
endmodule

// File: rtl/tag_anticoll_seq.sv
// Module: tag anticollision sequencer (top).
// Back-off, header, listening window, hold, ID frame repetition, command
// hand-off and quiet state. All state moves happen on hb_tick. mod_out comes
// from registered state only, so it changes only at half-bit boundaries.
// Assumes: rst_n is the power-up reset; id_bytes is stable while a frame is
// sent; the command decoder's flags are held for at least one half-bit.
module tag_anticoll_seq #(
    parameter int HALF_CYC   = 16,
    parameter int ID_BYTES   = 12,
    parameter int SILENCE_HB = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  car_stb,
    input  logic                  rdr_pulse,
    input  logic [8*ID_BYTES-1:0] id_bytes,
    input  logic                  wr_busy,
    input  logic                  cmd_quiet,
    input  logic                  cmd_done,
    input  logic                  glob_rel,
    output logic                  mod_out,
    output logic                  cmd_stb
);
    import tas_pkg::*;

    localparam int FRAME_HB = 2 * (8 * ID_BYTES + 2);
    localparam int BO_MAX   = HDR_HB * (1 << BO_BITS);
    localparam int CNT_W    = $clog2(tas_max3(FRAME_HB, BO_MAX, SILENCE_HB) + 1);
    localparam logic [HDR_HB-1:0] HDR_PAT = 8'b0111_1110;

    tas_state_e       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             hb_tick;
    logic             hb_pulse;
    logic             enter_bo;
    logic             fstart;
    logic             cmd_fire;
    logic [BO_BITS-1:0] draw;
    logic             cur_bit;
    logic             slot_hit;

    tas_timebase #(.HALF_CYC(HALF_CYC)) i_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .car_stb (car_stb),
        .hb_tick (hb_tick)
    );

    tas_pulse_catch i_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdr_pulse (rdr_pulse),
        .hb_tick   (hb_tick),
        .hb_pulse  (hb_pulse)
    );

    tas_lfsr i_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (id_bytes[BO_BITS-1:0]),
        .step  (hb_tick && enter_bo),
        .draw  (draw)
    );

    tas_frame_gen #(.ID_BYTES(ID_BYTES), .CNT_W(CNT_W)) i_fg (
        .clk      (clk),
        .rst_n    (rst_n),
        .hb_tick  (hb_tick),
        .tx_next  (st_n == ST_ID_TX),
        .start    (fstart),
        .idx_next (cnt_n),
        .id_bytes (id_bytes),
        .wr_busy  (wr_busy),
        .cur_bit  (cur_bit)
    );

    // Own acknowledge slot: second bit of the listening window.
    assign slot_hit = (cnt_q == CNT_W'(2)) || (cnt_q == CNT_W'(3));

    // Next-state and phase-counter logic, evaluated for the next hb_tick.
    always_comb begin
        st_n     = st_q;
        cnt_n    = cnt_q;
        enter_bo = 1'b0;
        fstart   = 1'b0;
        cmd_fire = 1'b0;
        unique case (st_q)
            ST_BACKOFF: begin
                if (cnt_q == '0) begin
                    st_n  = ST_HEADER;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            ST_HEADER: begin
                if (cnt_q == CNT_W'(HDR_HB - 1)) begin
                    st_n  = ST_LISTEN;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_LISTEN: begin
                if (hb_pulse) begin
                    cnt_n = '0;
                    if (slot_hit) begin
                        st_n   = ST_ID_TX;
                        fstart = 1'b1;
                    end else begin
                        st_n = ST_HOLD;
                    end
                end else if (cnt_q == CNT_W'(WIN_HB - 1)) begin
                    st_n     = ST_BACKOFF;
                    enter_bo = 1'b1;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_HOLD: begin
                if (hb_pulse) begin
                    cnt_n = '0;
                end else if (cnt_q == CNT_W'(SILENCE_HB - 1)) begin
                    st_n     = ST_BACKOFF;
                    enter_bo = 1'b1;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_ID_TX: begin
                if (cnt_q == CNT_W'(FRAME_HB - 1)) begin
                    st_n  = ST_ID_GAP;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_ID_GAP: begin
                if (hb_pulse) begin
                    st_n     = ST_CMD;
                    cnt_n    = '0;
                    cmd_fire = 1'b1;
                end else if (cnt_q == CNT_W'(WIN_HB - 1)) begin
                    st_n   = ST_ID_TX;
                    cnt_n  = '0;
                    fstart = 1'b1;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_CMD: begin
                if (cmd_quiet) begin
                    st_n = ST_QUIET;
                end else if (cmd_done) begin
                    st_n   = ST_ID_TX;
                    cnt_n  = '0;
                    fstart = 1'b1;
                end
            end
            ST_QUIET: begin
                if (glob_rel) begin
                    st_n     = ST_BACKOFF;
                    enter_bo = 1'b1;
                end
            end
            default: begin
                st_n = ST_BACKOFF;
            end
        endcase
        if (enter_bo) begin
            cnt_n = CNT_W'({draw, 3'b111});
        end
    end

    // Sequencer state and phase counter; reset starts the power-up back-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_BACKOFF;
            cnt_q <= CNT_W'({id_bytes[BO_BITS-1:0], 3'b111});
        end else if (hb_tick) begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // Command strobe, one clock at the half-bit edge that leaves a gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_stb <= 1'b0;
        end else begin
            cmd_stb <= hb_tick && cmd_fire;
        end
    end

    // Modulation level from state: header pattern or split-phase ID bit.
    always_comb begin
        mod_out = 1'b0;
        if (st_q == ST_HEADER) begin
            mod_out = HDR_PAT[cnt_q[2:0]];
        end else if (st_q == ST_ID_TX) begin
            mod_out = cur_bit ^ cnt_q[0];
        end
    end
endmodule

// File: rtl/tas_chk.sv
// Module: assertion checker for tag_anticoll_seq, attached with bind.
module tas_chk
    import tas_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       hb_tick,
    input tas_state_e st,
    input logic       mod_out,
    input logic       cmd_stb
);
    // R12
    mod_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hb_tick |=> $stable(mod_out));

    // R12
    state_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hb_tick |=> $stable(st));

    // R6
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

    // R6
    stb_from_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> (st == ST_CMD) && ($past(st) == ST_ID_GAP));

    // R10
    quiet_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_QUIET) |-> !mod_out);

    // R9
    hold_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> !mod_out);

    // R2
    hdr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HEADER) && ($past(st) != ST_HEADER)) |-> !mod_out);
endmodule

bind tag_anticoll_seq tas_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hb_tick (hb_tick),
    .st      (st_q),
    .mod_out (mod_out),
    .cmd_stb (cmd_stb)
);

// File: tb/test_tag_anticoll_seq.sv
module test_tag_anticoll_seq;
    localparam int H      = 4;
    localparam int NB     = 12;
    localparam int SIL    = 16;
    localparam int FHB    = 2 * (8 * NB + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          car_stb = 1'b1;
    logic          rdr_pulse = 1'b0;
    logic [8*NB-1:0] id_bytes = '0;
    logic          wr_busy = 1'b0;
    logic          cmd_quiet = 1'b0;
    logic          cmd_done = 1'b0;
    logic          glob_rel = 1'b0;
    logic          mod_out;
    logic          cmd_stb;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int stb_cnt = 0;
    int t_ref = 0;

    tag_anticoll_seq #(.HALF_CYC(H), .ID_BYTES(NB), .SILENCE_HB(SIL)) i_tag_anticoll_seq (
        .clk(clk), .rst_n(rst_n), .car_stb(car_stb), .rdr_pulse(rdr_pulse),
        .id_bytes(id_bytes), .wr_busy(wr_busy), .cmd_quiet(cmd_quiet),
        .cmd_done(cmd_done), .glob_rel(glob_rel), .mod_out(mod_out), .cmd_stb(cmd_stb)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && cmd_stb) stb_cnt <= stb_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected modulation of half-bit j of a frame.
    function automatic logic exp_hb(input int j, input logic [8*NB-1:0] ids, input bit busy);
        int b;
        int p;
        logic v;
        b = j / 2;
        if (b == 0) v = 1'b1;
        else if (b == 8 * NB + 1) v = 1'b0;
        else if (busy) v = 1'b0;
        else begin
            p = b - 1;
            v = ids[(p / 8) * 8 + 7 - (p % 8)];
        end
        return (j % 2 == 0) ? v : ~v;
    endfunction

    task automatic go(input int idx);
        while (cyc < t_ref + idx * H + 2) @(negedge clk);
    endtask

    task automatic pulse_at(input int idx);
        go(idx);
        rdr_pulse = 1'b1;
        @(negedge clk);
        rdr_pulse = 1'b0;
    endtask

    task automatic wait_rise(output int p);
        int lim;
        lim = 0;
        while (!mod_out && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
        p = cyc;
    endtask

    task automatic do_reset(input logic [8*NB-1:0] ids, output int r0);
        rst_n = 1'b0;
        id_bytes = ids;
        repeat (3) @(negedge clk);
        check(mod_out == 1'b0 && cmd_stb == 1'b0, "R1", "reset outputs", {mod_out, cmd_stb}, 0);
        rst_n = 1'b1;
        r0 = cyc;
    endtask

    task automatic first_header(input logic [8*NB-1:0] ids);
        int r0;
        int p;
        int expc;
        do_reset(ids, r0);
        wait_rise(p);
        expc = (8 * (int'(ids[2:0]) + 1) + 1) * H;
        check((p - r0) >= expc - 1 && (p - r0) <= expc + 1, "R1", "first header delay", p - r0, expc);
        t_ref = p;
    endtask

    task automatic check_header();
        int bad;
        bad = 0;
        for (int i = 0; i < 7; i++) begin
            go(i);
            if (mod_out !== ((i < 6) ? 1'b1 : 1'b0)) bad++;
        end
        check(bad == 0, "R2", "header pattern mismatches", bad, 0);
    endtask

    task automatic check_frame(input int st, input logic [8*NB-1:0] ids, input bit busy, input string req);
        int bad;
        int first;
        bad = 0;
        first = -1;
        for (int j = 0; j < FHB; j++) begin
            go(st + j);
            if (mod_out !== exp_hb(j, ids, busy)) begin
                bad++;
                if (first < 0) first = j;
            end
        end
        check(bad == 0, req, "frame half-bit mismatches (first index in log)", bad, 0);
        if (bad != 0) $display("  first bad half-bit %0d", first);
    endtask

    task automatic silent_range(input int a, input int b, input string req);
        int bad;
        bad = 0;
        for (int i = a; i <= b; i++) begin
            go(i);
            if (mod_out !== 1'b0) bad++;
        end
        check(bad == 0, req, "modulated half-bits in silent span", bad, 0);
    endtask

    task automatic next_rise(input int lo, input int hi, input string req);
        int p;
        go(lo - 1);
        wait_rise(p);
        check((p - t_ref) >= lo * H - 2 && (p - t_ref) <= hi * H + 2, req,
              "re-header offset in cycles", p - t_ref, lo * H);
        t_ref = p;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [8*NB-1:0] ids;
        int s0;
        void'($urandom(32'h1D7A_0C55));

        // Random ID frames with both extreme seeds; ack in either slot half.
        for (int it = 0; it < 4; it++) begin
            int ack;
            ids = {$urandom(), $urandom(), $urandom()};
            if (it == 0) ids[2:0] = 3'd0;
            if (it == 1) ids[2:0] = 3'd7;
            first_header(ids);                          // R1
            check_header();                             // R2
            silent_range(7, 8, "R2");
            ack = (it == 2) ? 10 : 9;                   // R3 both slot half-bits
            pulse_at(ack);
            check_frame(ack + 1, ids, 1'b0, "R3/R4");
            silent_range(ack + 1 + FHB, ack + FHB + 6, "R5");
            check_frame(ack + 7 + FHB, ids, 1'b0, "R5");
        end

        // Commands: strobe, resume with busy, quiet, release.
        ids = 96'hA5C3_0F1E_8877_6655_4433_2219;
        first_header(ids);
        s0 = stb_cnt;
        pulse_at(9);
        check_frame(10, ids, 1'b0, "R4");
        pulse_at(207);
        go(208);
        check(stb_cnt == s0 + 1, "R6", "cmd_stb count after gap pulse", stb_cnt - s0, 1);
        go(210);
        wr_busy = 1'b1;
        silent_range(208, 215, "R6");
        go(216);
        cmd_done = 1'b1;
        go(217);
        cmd_done = 1'b0;
        check_frame(217, ids, 1'b1, "R11/R7");
        go(413);
        wr_busy = 1'b0;
        pulse_at(414);
        go(416);
        check(stb_cnt == s0 + 2, "R6", "second cmd_stb", stb_cnt - s0, 2);
        cmd_quiet = 1'b1;
        go(417);
        cmd_quiet = 1'b0;
        pulse_at(420);
        pulse_at(430);
        silent_range(417, 450, "R10");
        check(stb_cnt == s0 + 2, "R10", "no cmd_stb while quiet", stb_cnt - s0, 2);
        go(452);
        glob_rel = 1'b1;
        go(453);
        glob_rel = 1'b0;
        next_rise(462, 518, "R10");

        // No acknowledge: new back-off and header again.
        ids = {$urandom(), $urandom(), $urandom()};
        first_header(ids);
        check_header();
        silent_range(7, 12, "R8");
        next_rise(22, 78, "R8");
        check_header();

        // Early foreign pulse, hold kept alive by traffic.
        ids = {$urandom(), $urandom(), $urandom()};
        first_header(ids);
        pulse_at(7);
        pulse_at(15);
        pulse_at(23);
        pulse_at(31);
        pulse_at(39);
        silent_range(8, 56, "R9");
        next_rise(65, 121, "R9");

        // Late foreign pulse in window half-bit 4.
        ids = {$urandom(), $urandom(), $urandom()};
        first_header(ids);
        pulse_at(11);
        silent_range(12, 36, "R9");
        next_rise(37, 93, "R9");

        // Timing at a different half-bit boundary count: header width R12.
        check_header();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule